// File: doc/BRIEF.md
# Counting-Ramp Converter Controller

This block is the digital half of a single-comparator analog-to-digital converter. It owns an N-bit binary counter whose value drives an external DAC, so the DAC output climbs as a staircase. An external comparator reports whether that staircase is still below the analog input. When a conversion is started, the counter is zeroed and then steps up by one code per clock. The count stops as soon as the comparator says the reference has caught up with the input. The frozen count is then captured as the result.

A conversion therefore takes a time that grows with the input level: one clock per code step, up to the full code range. If the staircase reaches the top code and the comparator still shows the input above it, the conversion ends anyway. In that case the result reads full scale and an overrange flag is set. Only one conversion runs at a time; the controller ignores any start request made while a conversion is running.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After reset, dacCode is zero, resultCode is zero, doneFlag is low and overRange is low.
- R2: A startReq sampled high while idle clears the counter, so dacCode is zero after that clock edge.
- R3: While converting, with cmpAbove high and dacCode below all ones, dacCode rises by exactly one on every clock edge.
- R4: The first edge in a conversion at which cmpAbove is low ends it. dacCode stops changing, and resultCode loads the dacCode value present at that edge.
- R5: doneFlag is high for exactly one cycle, the cycle after the edge that ends a conversion.
- R6: If cmpAbove is still high when dacCode is all ones, the conversion ends there. resultCode becomes all ones and overRange goes high. A conversion that ends because cmpAbove went low sets overRange low.
- R7: startReq has no effect while a conversion is running. The staircase neither restarts nor skips a step.
- R8: After a conversion ends, dacCode, resultCode and overRange hold their values until the next accepted start, whatever cmpAbove does.
- R9: Counting from the edge that accepts startReq, doneFlag rises after exactly k+1 further edges. Here k is the stopping code: the input's code, or all ones on overrange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request to begin a conversion, sampled while idle |
| cmpAbove | input | 1 | Comparator: high while the DAC reference is below the analog input |
| dacCode | output | CODE_W | Counter value driving the external DAC |
| doneFlag | output | 1 | One-cycle pulse when a conversion finishes |
| resultCode | output | CODE_W | Captured final count |
| overRange | output | 1 | Last conversion hit full scale without the comparator tripping |

## Verification
The bench builds the block with CODE_W set to 4, so the full staircase is only sixteen codes long. With that width, every stopping code from zero to all ones is reachable, and so is the overrange case with the input above full scale, all in a few dozen cycles per conversion. Random input levels are mixed with directed ones at zero, at all ones and above full scale. Start pulses are injected during conversions. The comparator input is toggled while the block is idle, to show that the held outputs ignore it.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RAMP = 1'b1
  } rampState_t;

  typedef struct packed {
    logic clrCount;
    logic incCount;
    logic loadResult;
    logic flagOver;
  } rampStrobe_t;

endpackage

// File: rtl/ramp_adc_fsm.sv
module ramp_adc_fsm
  import ramp_adc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cmpAbove,
  input  logic        atMax,
  output rampStrobe_t strobes
);

  rampState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobes.clrCount = 1'b1;
          stateNext        = ST_RAMP;
        end
      end
      ST_RAMP: begin
        if (!cmpAbove) begin
          strobes.loadResult = 1'b1;
          stateNext          = ST_IDLE;
        end else if (atMax) begin
          strobes.loadResult = 1'b1;
          strobes.flagOver   = 1'b1;
          stateNext          = ST_IDLE;
        end else begin
          strobes.incCount = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R7: a start request while ramping never clears the counter
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAMP) |-> !strobes.clrCount);

  // strobes stay mutually exclusive
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.clrCount, strobes.incCount, strobes.loadResult}));

  // R6: overrange only flagged together with a result load
  assert_over_with_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagOver |-> strobes.loadResult);

endmodule

// File: rtl/ramp_adc_datapath.sv
module ramp_adc_datapath
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobe_t       strobes,
  output logic              atMax,
  output logic [CODE_W-1:0] count,
  output logic [CODE_W-1:0] resultCode,
  output logic              overRange,
  output logic              doneFlag
);

  localparam logic [CODE_W-1:0] FULL_CODE = {CODE_W{1'b1}};

  assign atMax = (count == FULL_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.clrCount) begin
      count <= '0;
    end else if (strobes.incCount) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultCode <= '0;
      overRange  <= 1'b0;
      doneFlag   <= 1'b0;
    end else begin
      doneFlag <= strobes.loadResult;
      if (strobes.loadResult) begin
        resultCode <= count;
        overRange  <= strobes.flagOver;
      end
    end
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCount |=> (count == '0));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incCount |=> (count == $past(count) + 1'b1));

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadResult |=> (resultCode == $past(count)) && $stable(count));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !doneFlag);

  assert_over_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (resultCode == FULL_CODE));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.clrCount || strobes.loadResult) |=> $stable(resultCode) && $stable(overRange));

endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
  import ramp_adc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              cmpAbove,
  output logic [CODE_W-1:0] dacCode,
  output logic              doneFlag,
  output logic [CODE_W-1:0] resultCode,
  output logic              overRange
);

  rampStrobe_t strobes;
  logic        atMax;

  ramp_adc_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .cmpAbove (cmpAbove),
    .atMax    (atMax),
    .strobes  (strobes)
  );

  ramp_adc_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .atMax      (atMax),
    .count      (dacCode),
    .resultCode (resultCode),
    .overRange  (overRange),
    .doneFlag   (doneFlag)
  );

endmodule

// File: tb/sim_ramp_adc_ctrl.sv
module sim_ramp_adc_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 4;
  localparam int MAX_CODE   = (1 << CODE_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startReq = 1'b0;
  logic              cmpAbove;
  logic [CODE_W-1:0] dacCode;
  logic              doneFlag;
  logic [CODE_W-1:0] resultCode;
  logic              overRange;

  int unsigned target = 0;
  logic        idleOverride = 1'b0;
  logic        idleCmp = 1'b0;
  int          nChecks = 0;
  int          nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // external DAC plus comparator model
  assign cmpAbove = idleOverride ? idleCmp : (int'(dacCode) < int'(target));

  ramp_adc_ctrl #(.CODE_W(CODE_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpAbove(cmpAbove),
    .dacCode(dacCode), .doneFlag(doneFlag), .resultCode(resultCode),
    .overRange(overRange)
  );

  function automatic int expCode(int unsigned t);
    return (t > MAX_CODE) ? MAX_CODE : int'(t);
  endfunction

  function automatic logic expOver(int unsigned t);
    return t > MAX_CODE;
  endfunction

  task automatic check(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic convert(int unsigned t, bit inject);
    int edges = 0;
    bit seenDone = 0;
    target = t;
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R2 cleared", int'(dacCode), 0);
    while (!seenDone && edges < 40) begin
      if (inject && edges == 1) startReq = 1'b1;
      if (inject && edges == 2) startReq = 1'b0;
      @(negedge clk);
      edges++;
      if (doneFlag) seenDone = 1;
      else if (edges <= expCode(t)) check("R3/R7 staircase", int'(dacCode), edges);
    end
    startReq = 1'b0;
    check("R9 latency", edges, expCode(t) + 1);
    check("R4 result", int'(resultCode), expCode(t));
    check("R4 dac frozen", int'(dacCode), expCode(t));
    check("R6 overrange", int'(overRange), int'(expOver(t)));
    // idle: comparator wiggles, nothing may move
    idleOverride = 1'b1;
    for (int i = 0; i < 3; i++) begin
      idleCmp = ~idleCmp;
      @(negedge clk);
      if (i == 0) check("R5 done one cycle", int'(doneFlag), 0);
      check("R8 dac hold", int'(dacCode), expCode(t));
      check("R8 result hold", int'(resultCode), expCode(t));
      check("R8 over hold", int'(overRange), int'(expOver(t)));
    end
    idleOverride = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD * 3 + 2);
    check("R1 dac reset", int'(dacCode), 0);
    check("R1 result reset", int'(resultCode), 0);
    check("R1 done reset", int'(doneFlag), 0);
    check("R1 over reset", int'(overRange), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    convert(0, 0);
    convert(1, 0);
    convert(MAX_CODE, 0);
    convert(MAX_CODE + 1, 0);
    convert(MAX_CODE + 4, 1);
    convert(9, 1);
    // random levels
    for (int n = 0; n < 40; n++) begin
      convert($urandom_range(MAX_CODE + 3, 0), bit'($urandom_range(1, 0)));
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule